// File: doc/BRIEF.md
# Seconds/Minutes/Hours Clock with Don't-Care Alarm

This block keeps a time of day as three bytes (seconds, minutes, hours) and advances it once per second. The second is counted out from a strobe that arrives at the slow oscillator rate, normally 32768 strobes per second. Each byte is held either as two packed decimal digits or as a plain binary number. The hour byte can use 24-hour form or 12-hour form with a PM flag. A host writes the time bytes and three alarm bytes directly. A freeze input stops the time from advancing, so the host can load a consistent value.

A small state machine tracks where the second counter sits. It has four named states. `PS_RUN` counts strobes outside the final window. `PS_PRE` counts strobes inside the update-in-progress window. `PS_HOLD` keeps the count because the divider control holds a stop code. `PS_DIVRST` keeps the divider in reset. The transitions are as follows. Any state goes to `PS_DIVRST` on a reset code and to `PS_HOLD` on a stop code. `PS_DIVRST` goes to `PS_RUN` when a run code returns. `PS_HOLD` goes back to `PS_RUN` or `PS_PRE`, depending on the kept count. `PS_RUN` and `PS_PRE` move between each other as strobes cross the window start, and `PS_PRE` wraps to `PS_RUN` on the strobe that completes the second.

Every completed second advances the time unless the freeze input is high. An advance gives an update pulse. It also gives an alarm pulse when the new time matches every alarm byte that is not a don't-care.

Top module: `tod_alarm_clock`

## Requirements
- R1: With `bin_mode`=0 each time byte holds the tens digit in bits 7:4 and the units digit in bits 3:0. With `bin_mode`=1 the byte holds the plain binary value.
- R2: With `hr24_mode`=0 the hour byte holds 1 to 12 in bits 6:0, and bit 7 is set for afternoon hours. Internal hour 0 reads as 12 with bit 7 clear. Internal hours 12 to 23 set bit 7.
- R3: Seconds wrap from 59 (or any larger decoded value) to 0 and carry into minutes. Minutes wrap the same way and carry into hours. Hours wrap from internal 23 to 0. A byte that gets no carry is left exactly as stored.
- R4: An alarm byte whose bits 7:6 are both 1 is a don't-care and matches any value.
- R5: `alarm_pulse` is high for one cycle, in the same cycle as `upd_pulse`, when every alarm byte that is not a don't-care equals the new time byte, compared as raw bytes.
- R6: `upd_pulse` is high for one cycle after each advance. It appears in the cycle after the clock edge that takes the strobe which completes the second.
- R7: `uip` is high while the second counter holds one of its last `UIP_TICKS` values before the update. It is low while `set_freeze` is high and while the divider is stopped or in reset.
- R8: While `set_freeze` is 1 the time bytes do not advance and neither pulse is produced. Host writes still take effect.
- R9: `div_sel` values 6 and 7 hold the divider in reset. When `div_sel` returns to a run code (0, 1 or 2), the first update comes `TICKS_PER_SEC`/2 strobes later. The strobe in the cycle of leaving reset is not counted.
- R10: `div_sel` values 3, 4 and 5 stop the counting without clearing it. The time does not advance and `uip` stays low.
- R11: Changing `bin_mode` or `hr24_mode` does not rewrite the stored bytes. The next advance decodes them under the new mode.
- R12: A host write with `wr_en`=1 stores `wr_data` according to `wr_sel`: 0 seconds, 1 minutes, 2 hours, 4 alarm seconds, 5 alarm minutes, 6 alarm hours. Codes 3 and 7 are ignored. A write to a time byte in an advance cycle replaces the advanced value of that byte.
- R13: After reset all time and alarm bytes are 0x00, the counter is 0, and `uip`, `upd_pulse` and `alarm_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe at the oscillator rate |
| div_sel | input | 3 | Divider control: 0-2 run, 3-5 stop, 6-7 reset |
| set_freeze | input | 1 | Freezes time advance while high |
| bin_mode | input | 1 | 1 selects binary bytes, 0 packed decimal |
| hr24_mode | input | 1 | 1 selects 24-hour form, 0 12-hour form with PM flag |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Byte selected by a host write |
| wr_data | input | 8 | Host write data |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| uip | output | 1 | Update-in-progress status |
| upd_pulse | output | 1 | One-cycle pulse per advance |
| alarm_pulse | output | 1 | One-cycle pulse on an alarm match |

## Verification
The bench goes after the full carry chain from 23:59:59, including the 12-hour cases 11 PM to 12 AM and 11 AM to 12 PM. A design that handled these wrongly would show hour 0 or 0x00, or would set the PM flag on the wrong side of noon. It checks the half-second delay after leaving divider reset and the exact eight-strobe `uip` window. An off-by-one counter would move the first update pulse, or would widen or narrow the window by a cycle. It checks don't-care alarm fields against mismatching fixed fields, the freeze and stop codes, and a mode change made without rewriting the bytes. A design that converted stored bytes on a mode change, or that advanced while frozen, would then show the wrong byte at the next update. A reference model runs alongside on every clock under random writes and sparse strobes, so that races between an advance and a write in the same cycle are caught.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_PRE    = 2'd1,
        PS_HOLD   = 2'd2,
        PS_DIVRST = 2'd3
    } pre_state_e;

    localparam int          BYTE_W    = 8;
    localparam int          NUM_ALM   = 3;
    localparam logic [2:0]  SEL_SEC   = 3'd0;
    localparam logic [2:0]  SEL_MIN   = 3'd1;
    localparam logic [2:0]  SEL_HOUR  = 3'd2;
    localparam logic [2:0]  SEL_ASEC  = 3'd4;

    // byte -> numeric value under the current data mode
    function automatic logic [7:0] field_dec(input logic [7:0] b, input logic bin);
        logic [7:0] t;
        if (bin) return b;
        t = {4'd0, b[7:4]};
        return (t << 3) + (t << 1) + {4'd0, b[3:0]};
    endfunction

    // numeric value (0..59) -> byte under the current data mode
    function automatic logic [7:0] field_enc(input logic [7:0] v, input logic bin);
        logic [7:0] tens;
        logic [7:0] units;
        if (bin) return v;
        tens  = v / 8'd10;
        units = v - tens * 8'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    // hour byte -> internal 0..23 value
    function automatic logic [7:0] hour_dec(input logic [7:0] b, input logic bin,
                                            input logic h24);
        logic [7:0] t;
        if (h24) return field_dec(b, bin);
        t = field_dec({1'b0, b[6:0]}, bin) % 8'd12;
        return t + (b[7] ? 8'd12 : 8'd0);
    endfunction

    // internal 0..23 value -> hour byte
    function automatic logic [7:0] hour_enc(input logic [7:0] h, input logic bin,
                                            input logic h24);
        logic [7:0] t;
        logic [7:0] r;
        if (h24) return field_enc(h, bin);
        t = h % 8'd12;
        if (t == 8'd0) t = 8'd12;
        r    = field_enc(t, bin);
        r[7] = (h >= 8'd12);
        return r;
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler
    import tod_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] div_sel,
    output pre_state_e state,
    output logic       upd_tick
);

    localparam int            CW   = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] HALF = CW'(TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] WIN  = CW'(TICKS_PER_SEC - UIP_TICKS);

    pre_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          div_rst, div_ok;

    assign div_rst = div_sel[2] & div_sel[1];
    assign div_ok  = (div_sel <= 3'd2);

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        upd_tick = 1'b0;
        if (div_rst) begin
            state_d = PS_DIVRST;
            cnt_d   = HALF;
        end else if (!div_ok) begin
            state_d = PS_HOLD;
        end else begin
            unique case (state_q)
                PS_DIVRST: state_d = PS_RUN;
                PS_HOLD:   state_d = (cnt_q >= WIN) ? PS_PRE : PS_RUN;
                PS_RUN, PS_PRE: begin
                    if (tick) begin
                        if (cnt_q == LAST) begin
                            cnt_d    = '0;
                            upd_tick = 1'b1;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                        state_d = (cnt_d >= WIN) ? PS_PRE : PS_RUN;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state = state_q;

    p_divrst_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DIVRST) |-> (cnt_q == HALF));

    p_hold_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_HOLD && $past(state_q) == PS_HOLD) |-> (cnt_q == $past(cnt_q)));

    p_pre_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PRE) |-> (cnt_q >= WIN));

endmodule

// File: rtl/tod_time_regs.sv
module tod_time_regs
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              bin_mode,
    input  logic              hr24_mode,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] sec_q,
    output logic [BYTE_W-1:0] min_q,
    output logic [BYTE_W-1:0] hour_q,
    output logic [BYTE_W-1:0] sec_n,
    output logic [BYTE_W-1:0] min_n,
    output logic [BYTE_W-1:0] hour_n
);

    logic [7:0] s_v, m_v, h_v;

    always_comb begin
        s_v    = field_dec(sec_q, bin_mode);
        m_v    = field_dec(min_q, bin_mode);
        h_v    = hour_dec(hour_q, bin_mode, hr24_mode);
        sec_n  = (s_v >= 8'd59) ? field_enc(8'd0, bin_mode) : field_enc(s_v + 8'd1, bin_mode);
        min_n  = min_q;
        hour_n = hour_q;
        if (s_v >= 8'd59) begin
            if (m_v >= 8'd59) begin
                min_n  = field_enc(8'd0, bin_mode);
                hour_n = hour_enc((h_v >= 8'd23) ? 8'd0 : h_v + 8'd1, bin_mode, hr24_mode);
            end else begin
                min_n = field_enc(m_v + 8'd1, bin_mode);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= '0;
            min_q  <= '0;
            hour_q <= '0;
        end else begin
            if (advance) begin
                sec_q  <= sec_n;
                min_q  <= min_n;
                hour_q <= hour_n;
            end
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_SEC:  sec_q  <= wr_data;
                    SEL_MIN:  min_q  <= wr_data;
                    SEL_HOUR: hour_q <= wr_data;
                    default:  ;
                endcase
            end
        end
    end

    // R3: with no advance and no write the time bytes hold
    p_hold_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(advance) && !$past(wr_en)) |-> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)));

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                wr_sel,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic [NUM_ALM*BYTE_W-1:0] cand,
    output logic                      match
);

    logic [BYTE_W-1:0]  alm_q [NUM_ALM];
    logic [NUM_ALM-1:0] hit;

    for (genvar g = 0; g < NUM_ALM; g++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alm_q[g] <= '0;
            else if (wr_en && wr_sel == SEL_ASEC + 3'(g))
                alm_q[g] <= wr_data;
        end
        assign hit[g] = (alm_q[g][7:6] == 2'b11) ||
                        (alm_q[g] == cand[g*BYTE_W +: BYTE_W]);
    end

    assign match = &hit;

endmodule

// File: rtl/tod_alarm_clock.sv
module tod_alarm_clock
    import tod_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] div_sel,
    input  logic       set_freeze,
    input  logic       bin_mode,
    input  logic       hr24_mode,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic       uip,
    output logic       upd_pulse,
    output logic       alarm_pulse
);

    pre_state_e state;
    logic       upd_tick, advance, match;
    logic [7:0] sec_n, min_n, hour_n;

    tod_prescaler #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_TICKS     (UIP_TICKS)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .div_sel  (div_sel),
        .state    (state),
        .upd_tick (upd_tick)
    );

    assign advance = upd_tick & ~set_freeze;

    tod_time_regs u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .bin_mode  (bin_mode),
        .hr24_mode (hr24_mode),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .sec_q     (sec_o),
        .min_q     (min_o),
        .hour_q    (hour_o),
        .sec_n     (sec_n),
        .min_n     (min_n),
        .hour_n    (hour_n)
    );

    tod_alarm_match u_alm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cand    ({hour_n, min_n, sec_n}),
        .match   (match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_pulse   <= 1'b0;
            alarm_pulse <= 1'b0;
        end else begin
            upd_pulse   <= advance;
            alarm_pulse <= advance & match;
        end
    end

    assign uip = (state == PS_PRE) & ~set_freeze;

    p_alarm_with_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |-> upd_pulse);

    p_upd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> !upd_pulse);

    p_no_upd_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> !$past(set_freeze));

    p_upd_after_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> ($past(state) == PS_PRE));

endmodule

// File: tb/test_tod_alarm_clock.sv
module test_tod_alarm_clock;

    localparam int TPS  = 32;
    localparam int UIPT = 8;
    localparam int HALF = TPS / 2;
    localparam int WIN  = TPS - UIPT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       set_freeze = 1'b0, bin_mode = 1'b0, hr24_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o;
    logic       uip, upd_pulse, alarm_pulse;

    tod_alarm_clock #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) i_tod_alarm_clock (
        .clk(clk), .rst_n(rst_n), .tick(tick), .div_sel(div_sel),
        .set_freeze(set_freeze), .bin_mode(bin_mode), .hr24_mode(hr24_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .uip(uip), .upd_pulse(upd_pulse), .alarm_pulse(alarm_pulse));

    always #2 clk = ~clk;   // 250 MHz

    int n_chk = 0, n_fail = 0, cycles = 0, tick_every = 1;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // ---------------- reference model ----------------
    int m_cnt = 0, m_st = 0;   // 0 counting, 1 stopped, 2 divider reset
    int m_t[3] = '{0, 0, 0};   // sec, min, hour bytes
    int m_a[3] = '{0, 0, 0};
    int m_upd = 0, m_alm = 0;

    function automatic int mdec(int b, int bin);
        return bin ? b : (b / 16) * 10 + (b % 16);
    endfunction
    function automatic int menc(int v, int bin);
        return bin ? v : (v / 10) * 16 + (v % 10);
    endfunction
    function automatic int mhdec(int b, int bin, int h24);
        if (h24) return mdec(b, bin);
        return (mdec(b % 128, bin) % 12) + ((b >= 128) ? 12 : 0);
    endfunction
    function automatic int mhenc(int h, int bin, int h24);
        int t;
        if (h24) return menc(h, bin);
        t = (h % 12 == 0) ? 12 : h % 12;
        return menc(t, bin) + ((h >= 12) ? 128 : 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_st = 0; m_upd = 0; m_alm = 0;
            foreach (m_t[i]) begin m_t[i] = 0; m_a[i] = 0; end
        end else begin
            int upd, nt[3], s, m, h, hit;
            upd = 0;
            if (div_sel >= 6) begin m_st = 2; m_cnt = HALF; end
            else if (div_sel >= 3) m_st = 1;
            else if (m_st != 0) m_st = 0;
            else if (tick) begin
                if (m_cnt == TPS - 1) begin m_cnt = 0; upd = 1; end
                else m_cnt++;
            end
            m_upd = 0; m_alm = 0;
            if (upd && !set_freeze) begin
                s = mdec(m_t[0], bin_mode); m = mdec(m_t[1], bin_mode);
                h = mhdec(m_t[2], bin_mode, hr24_mode);
                nt[0] = menc((s + 1) % 60 * (s < 59 ? 1 : 0), bin_mode);
                nt[1] = m_t[1]; nt[2] = m_t[2];
                if (s >= 59) begin
                    if (m >= 59) begin
                        nt[1] = menc(0, bin_mode);
                        nt[2] = mhenc(h >= 23 ? 0 : h + 1, bin_mode, hr24_mode);
                    end else nt[1] = menc(m + 1, bin_mode);
                end
                hit = 1;
                for (int i = 0; i < 3; i++)
                    if (!((m_a[i] / 64) == 3 || m_a[i] == nt[i])) hit = 0;
                m_upd = 1; m_alm = hit;
                for (int i = 0; i < 3; i++) m_t[i] = nt[i];
            end
            if (wr_en) begin
                if (wr_sel <= 2) m_t[wr_sel] = wr_data;
                else if (wr_sel >= 4 && wr_sel <= 6) m_a[wr_sel - 4] = wr_data;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            chk("R3 sec_o", sec_o, m_t[0]);
            chk("R3 min_o", min_o, m_t[1]);
            chk("R2 hour_o", hour_o, m_t[2]);
            chk("R7 uip", uip, (m_st == 0 && m_cnt >= WIN && !set_freeze));
            chk("R6 upd_pulse", upd_pulse, m_upd);
            chk("R5 alarm_pulse", alarm_pulse, m_alm);
        end
    end

    // strobe generator
    initial forever begin
        @(posedge clk); #1;
        cycles++;
        tick = (tick_every <= 1) ? 1'b1 : (cycles % tick_every == 0);
    end

    // watchdog
    initial begin
        wait (cycles > 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired R6 actual=%0d expected=<190000", cycles);
            finished = 1;
            summary();
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        @(posedge clk); #1; set_freeze = 1;
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
        set_freeze = 0;
    endtask

    task automatic wait_upd();
        int k;
        k = 0;
        do begin @(negedge clk); k++; end while (!upd_pulse && k < 300);
        if (k >= 300) chk("R6 update timeout", 0, 1);
    endtask

    initial begin
        int n;
        int cnt_uip;
        // R13 reset state
        repeat (3) @(negedge clk);
        chk("R13 sec reset", sec_o, 8'h00);
        chk("R13 hour reset", hour_o, 8'h00);
        chk("R13 uip reset", uip, 0);
        chk("R13 upd reset", upd_pulse, 0);
        @(posedge clk); #1; rst_n = 1;

        // R4 all-wildcard alarm fires on each update
        wr(3'd4, 8'hC0); wr(3'd5, 8'hC7); wr(3'd6, 8'hFF);
        wait_upd(); chk("R4 wildcard alarm", alarm_pulse, 1);
        wait_upd(); chk("R4 wildcard alarm again", alarm_pulse, 1);

        // R3 full carry in packed decimal, 24-hour
        set_time(8'h23, 8'h59, 8'h58);
        wait_upd(); chk("R3 sec 59", sec_o, 8'h59);
        wait_upd();
        chk("R3 sec wrap", sec_o, 8'h00); chk("R3 min wrap", min_o, 8'h00);
        chk("R3 hour wrap", hour_o, 8'h00);

        // R2 12-hour transitions
        hr24_mode = 0;
        set_time(8'h91, 8'h59, 8'h59);
        wait_upd(); chk("R2 11PM to 12AM", hour_o, 8'h12);
        set_time(8'h11, 8'h59, 8'h59);
        wait_upd(); chk("R2 11AM to 12PM", hour_o, 8'h92);

        // R1 binary mode and packed decimal digits
        hr24_mode = 1; bin_mode = 1;
        set_time(8'd23, 8'd59, 8'd59);
        wait_upd(); chk("R1 binary hour wrap", hour_o, 8'd0);
        set_time(8'd5, 8'd0, 8'd9);
        wait_upd(); chk("R1 binary sec 10", sec_o, 8'h0A);
        bin_mode = 0;
        set_time(8'h05, 8'h00, 8'h09);
        wait_upd(); chk("R1 decimal sec 10", sec_o, 8'h10);

        // R5 alarm with fixed seconds, wildcard min/hour
        wr(3'd4, 8'h05); wr(3'd5, 8'hC0); wr(3'd6, 8'hFF);
        set_time(8'h07, 8'h00, 8'h03);
        wait_upd(); chk("R5 no alarm at 04", alarm_pulse, 0);
        wait_upd(); chk("R5 alarm at 05", alarm_pulse, 1);
        wr(3'd5, 8'h12);
        set_time(8'h07, 8'h00, 8'h04);
        wait_upd(); chk("R5 minute mismatch blocks alarm", alarm_pulse, 0);
        wr(3'd5, 8'h00); wr(3'd6, 8'h07);
        set_time(8'h07, 8'h00, 8'h04);
        wait_upd(); chk("R5 all fields match", alarm_pulse, 1);

        // R7 uip window length
        wait_upd();
        cnt_uip = 0;
        do begin @(negedge clk); if (uip) cnt_uip++; end while (!upd_pulse);
        chk("R7 uip window cycles", cnt_uip, UIPT);

        // R8 freeze: no advance, writes land
        @(posedge clk); #1; set_freeze = 1;
        wr(3'd0, 8'h30);
        n = 0;
        repeat (80) begin @(negedge clk); if (upd_pulse) n++; end
        chk("R8 frozen sec", sec_o, 8'h30);
        chk("R8 no pulses while frozen", n, 0);
        @(posedge clk); #1; set_freeze = 0;

        // R10 stop codes
        @(posedge clk); #1; div_sel = 3'd4;
        n = 0;
        repeat (80) begin @(negedge clk); if (upd_pulse || uip) n++; end
        chk("R10 stopped divider quiet", n, 0);
        chk("R10 stopped sec held", sec_o, m_t[0]);
        @(posedge clk); #1; div_sel = 3'd0;

        // R9 half-second after leaving divider reset
        @(posedge clk); #1; div_sel = 3'd6;
        step(40);
        chk("R9 uip low in reset", uip, 0);
        div_sel = 3'd1;
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!upd_pulse && n < 100);
        chk("R9 edges to first update", n, HALF + 1);

        // R11 mode change keeps bytes
        set_time(8'h01, 8'h00, 8'h19);
        @(posedge clk); #1; set_freeze = 1; bin_mode = 1;
        @(negedge clk); chk("R11 byte kept after switch", sec_o, 8'h19);
        @(posedge clk); #1; set_freeze = 0;
        wait_upd(); chk("R11 decoded under new mode", sec_o, 8'h1A);
        bin_mode = 0;

        // R12 ignored codes
        set_time(8'h02, 8'h03, 8'h04);
        @(posedge clk); #1; set_freeze = 1;
        wr(3'd3, 8'h55); wr(3'd7, 8'h66);
        @(negedge clk);
        chk("R12 code 3/7 sec", sec_o, 8'h04);
        chk("R12 code 3/7 min", min_o, 8'h03);
        chk("R12 code 3/7 hour", hour_o, 8'h02);
        @(posedge clk); #1; set_freeze = 0;

        // R12 random writes and modes with sparse strobes, compared each cycle
        tick_every = 3;
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            wr_en = ($urandom % 40 == 0);
            wr_sel = 3'($urandom % 8);
            wr_data = 8'($urandom);
            if ($urandom % 500 == 0) bin_mode = ~bin_mode;
            if ($urandom % 500 == 0) hr24_mode = ~hr24_mode;
            if ($urandom % 300 == 0) set_freeze = ~set_freeze;
        end
        wr_en = 0; set_freeze = 0;
        step(5);

        finished = 1;
        summary();
    end

endmodule